// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Interface

This block is the byte-wide register front end of a three-channel interval timer. A host talks to it over a 2-bit address: addresses 0, 1 and 2 are the data ports of the three counter channels, and address 3 is the control port. Control bytes set a channel's byte access mode, operating mode and BCD flag. They also issue counter latch commands and multi-channel read-back commands. Data bytes are gathered into 16-bit load values, and data reads return status bytes, frozen counts or live counts one byte at a time.

The counting itself lives in the channels, outside this block. For each channel the block drives a one-cycle load strobe with a 16-bit value, and it drives the current operating mode continuously. It takes back each channel's live 16-bit count and its output level. Read data is combinational from the current address and state. The side effects of a read (status release, latch release, byte toggle) take place at the clock edge on which the read strobe is high. Write and read strobes are expected one at a time.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, every channel uses low-then-high access (code 3), operating mode 3 and binary counting, with no load strobe, no pending latch and all byte toggles cleared.
- R2: A control byte written to address 3 is split as channel select in bits 7:6, access code in bits 5:4, operating mode in bits 3:1 and BCD flag in bit 0. A status byte reads back as {output level, 0, access code, operating mode, BCD} from bit 7 down to bit 0.
- R3: With access code 1 a data write loads {8'h00, byte}. With access code 2 it loads {byte, 8'h00}. Either load is strobed on the addressed channel in the cycle after the write.
- R4: With access code 3 the first data write only stores the low byte and gives no strobe. The second write strobes the load of {byte, stored low byte} and returns the write toggle to the low byte.
- R5: Access code 0 freezes the channel's live count, but only when no frozen count is still waiting. While one is waiting, further latch commands are ignored.
- R6: A frozen count taken under access code 3 is returned low byte then high byte, and is released only after its high byte has been read. Under codes 1 and 2 it is released after one read (low or high byte respectively). After release, reads return the live count.
- R7: Live reads under access code 3 alternate low byte, high byte, low byte and so on. Under code 1 they return the low byte and under code 2 the high byte.
- R8: A control byte with select 3 is a read-back. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 at 0 freezes the count of each picked channel, and bit 4 at 0 captures its status. Any number of channels may be picked at once.
- R9: A data read returns a pending status byte before any frozen count. A status capture is ignored while an earlier status is unread.
- R10: A control byte with a nonzero access code clears that channel's read and write byte toggles.
- R11: A read of address 3 returns 8'hFF and changes no state.
- R12: The mode output of each channel (3 bits per channel, channel 0 lowest) changes only after a control byte that carries a nonzero access code for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 2 | 0 to 2 select a channel data port, 3 selects the control port |
| host_wdata | input | 8 | Write byte |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rd | input | 1 | Read strobe, side effects at the clock edge |
| host_rdata | output | 8 | Read byte for the current address |
| ch_load | output | NUM_CH | One-cycle load strobe per channel |
| ch_value | output | 16*NUM_CH | Load value per channel, channel 0 in the low bits |
| ch_mode | output | 3*NUM_CH | Operating mode per channel |
| ch_count | input | 16*NUM_CH | Live count from each channel |
| ch_out | input | NUM_CH | Output level of each channel |

## Verification
The bench builds the block with its default of three channels. At that value all four select codes are in use: three reach a channel and the fourth is the read-back command. All three read-back channel bits can therefore be set in one command. The bench mixes such a two-channel read-back with a pending single-channel status, so that status precedence, hold-once latching and the release order of frozen counts are checked together on separate channels.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] SEL_READBACK = 2'd3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  // Frozen-count state uses the access encoding of the channel at capture.
  localparam logic [1:0] FRZ_NONE = 2'd0;
  localparam logic [1:0] FRZ_LO   = 2'd1;
  localparam logic [1:0] FRZ_HI   = 2'd2;
  localparam logic [1:0] FRZ_WORD = 2'd3;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctrl_byte_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output ctrl_byte_t        cfg_byte,
  output logic [NUM_CH-1:0] cfg_wr,
  output logic [NUM_CH-1:0] frz_req,
  output logic [NUM_CH-1:0] stat_req,
  output logic [NUM_CH-1:0] data_wr,
  output logic [NUM_CH-1:0] data_rd
);
  logic ctrl_wr;
  logic is_rb;
  logic rb_no_cnt;
  logic rb_no_stat;

  assign cfg_byte   = ctrl_byte_t'(host_wdata);
  assign ctrl_wr    = host_wr && (host_addr == CTRL_ADDR);
  assign is_rb      = (cfg_byte.sel == SEL_READBACK);
  assign rb_no_cnt  = host_wdata[5];
  assign rb_no_stat = host_wdata[4];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    logic rb_pick;
    assign hit       = (cfg_byte.sel == 2'(i));
    assign rb_pick   = host_wdata[i+1];
    assign cfg_wr[i] = ctrl_wr && !is_rb && hit && (cfg_byte.acc != ACC_LATCH);
    assign frz_req[i] = ctrl_wr && (is_rb ? (rb_pick && !rb_no_cnt)
                                          : (hit && cfg_byte.acc == ACC_LATCH));
    assign stat_req[i] = ctrl_wr && is_rb && rb_pick && !rb_no_stat;
    assign data_wr[i]  = host_wr && (host_addr == 2'(i));
    assign data_rd[i]  = host_rd && (host_addr == 2'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  ctrl_byte_t        cfg_byte,
  input  logic              frz_req,
  input  logic              stat_req,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              data_rd,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rdata,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [MODE_W-1:0] op_mode
);
  acc_e              acc_q, acc_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic              bcd_q, bcd_n;
  logic              wtog_q, wtog_n;
  logic              rtog_q, rtog_n;
  logic [BYTE_W-1:0] wlo_q, wlo_n;
  logic [1:0]        frz_q, frz_n;
  logic [CNT_W-1:0]  fval_q, fval_n;
  logic              spend_q, spend_n;
  logic [BYTE_W-1:0] sval_q, sval_n;
  logic              ld_q, ld_n;
  logic [CNT_W-1:0]  ldv_q, ldv_n;

  always_comb begin
    acc_n   = acc_q;
    mode_n  = mode_q;
    bcd_n   = bcd_q;
    wtog_n  = wtog_q;
    rtog_n  = rtog_q;
    wlo_n   = wlo_q;
    frz_n   = frz_q;
    fval_n  = fval_q;
    spend_n = spend_q;
    sval_n  = sval_q;
    ld_n    = 1'b0;
    ldv_n   = ldv_q;

    // Read side effects: status first, then frozen count, then live toggle.
    if (data_rd) begin
      if (spend_q) begin
        spend_n = 1'b0;
      end else if (frz_q != FRZ_NONE) begin
        frz_n = (frz_q == FRZ_WORD) ? FRZ_HI : FRZ_NONE;
      end else if (acc_q == ACC_WORD) begin
        rtog_n = ~rtog_q;
      end
    end

    if (frz_req && (frz_q == FRZ_NONE)) begin
      frz_n  = acc_q;
      fval_n = live_cnt;
    end

    if (stat_req && !spend_q) begin
      spend_n = 1'b1;
      sval_n  = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
    end

    if (cfg_wr) begin
      acc_n  = cfg_byte.acc;
      mode_n = cfg_byte.mode;
      bcd_n  = cfg_byte.bcd;
      wtog_n = 1'b0;
      rtog_n = 1'b0;
    end

    if (data_wr) begin
      unique case (acc_q)
        ACC_LO: begin
          ld_n  = 1'b1;
          ldv_n = {{BYTE_W{1'b0}}, wdata};
        end
        ACC_HI: begin
          ld_n  = 1'b1;
          ldv_n = {wdata, {BYTE_W{1'b0}}};
        end
        ACC_WORD: begin
          if (!wtog_q) begin
            wlo_n  = wdata;
            wtog_n = 1'b1;
          end else begin
            ld_n   = 1'b1;
            ldv_n  = {wdata, wlo_q};
            wtog_n = 1'b0;
          end
        end
        default: begin
          ld_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_WORD;
      mode_q  <= 3'd3;
      bcd_q   <= 1'b0;
      wtog_q  <= 1'b0;
      rtog_q  <= 1'b0;
      wlo_q   <= '0;
      frz_q   <= FRZ_NONE;
      fval_q  <= '0;
      spend_q <= 1'b0;
      sval_q  <= '0;
      ld_q    <= 1'b0;
      ldv_q   <= '0;
    end else begin
      acc_q   <= acc_n;
      mode_q  <= mode_n;
      bcd_q   <= bcd_n;
      wtog_q  <= wtog_n;
      rtog_q  <= rtog_n;
      wlo_q   <= wlo_n;
      frz_q   <= frz_n;
      fval_q  <= fval_n;
      spend_q <= spend_n;
      sval_q  <= sval_n;
      ld_q    <= ld_n;
      ldv_q   <= ldv_n;
    end
  end

  always_comb begin
    if (spend_q) begin
      rdata = sval_q;
    end else if (frz_q == FRZ_HI) begin
      rdata = fval_q[CNT_W-1:BYTE_W];
    end else if (frz_q != FRZ_NONE) begin
      rdata = fval_q[BYTE_W-1:0];
    end else begin
      unique case (acc_q)
        ACC_HI:   rdata = live_cnt[CNT_W-1:BYTE_W];
        ACC_WORD: rdata = rtog_q ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
        default:  rdata = live_cnt[BYTE_W-1:0];
      endcase
    end
  end

  assign load_stb = ld_q;
  assign load_val = ldv_q;
  assign op_mode  = mode_q;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [NUM_CH*BYTE_W-1:0] ch_rdata,
  output logic [BYTE_W-1:0]        host_rdata
);
  always_comb begin
    host_rdata = {BYTE_W{1'b1}};
    for (int i = 0; i < NUM_CH; i++) begin
      if (host_addr == 2'(i)) begin
        host_rdata = ch_rdata[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [BYTE_W-1:0]        host_wdata,
  input  logic                     host_wr,
  input  logic                     host_rd,
  output logic [BYTE_W-1:0]        host_rdata,
  output logic [NUM_CH-1:0]        ch_load,
  output logic [NUM_CH*CNT_W-1:0]  ch_value,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  input  logic [NUM_CH*CNT_W-1:0]  ch_count,
  input  logic [NUM_CH-1:0]        ch_out
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  ctrl_byte_t               cfg_byte;
  logic [NUM_CH-1:0]        cfg_wr;
  logic [NUM_CH-1:0]        frz_req;
  logic [NUM_CH-1:0]        stat_req;
  logic [NUM_CH-1:0]        data_wr;
  logic [NUM_CH-1:0]        data_rd;
  logic [NUM_CH*BYTE_W-1:0] ch_rdata;

  tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .cfg_byte   (cfg_byte),
    .cfg_wr     (cfg_wr),
    .frz_req    (frz_req),
    .stat_req   (stat_req),
    .data_wr    (data_wr),
    .data_rd    (data_rd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .cfg_wr   (cfg_wr[i]),
      .cfg_byte (cfg_byte),
      .frz_req  (frz_req[i]),
      .stat_req (stat_req[i]),
      .data_wr  (data_wr[i]),
      .wdata    (host_wdata),
      .data_rd  (data_rd[i]),
      .live_cnt (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl  (ch_out[i]),
      .rdata    (ch_rdata[i*BYTE_W +: BYTE_W]),
      .load_stb (ch_load[i]),
      .load_val (ch_value[i*CNT_W +: CNT_W]),
      .op_mode  (ch_mode[i*MODE_W +: MODE_W])
    );
  end

  tmr_rd_mux #(.NUM_CH(NUM_CH)) u_rmux (
    .host_addr  (host_addr),
    .ch_rdata   (ch_rdata),
    .host_rdata (host_rdata)
  );
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        host_addr,
  input logic                     host_wr,
  input logic                     host_rd,
  input logic [BYTE_W-1:0]        host_rdata,
  input logic [NUM_CH-1:0]        ch_load,
  input logic [NUM_CH*MODE_W-1:0] ch_mode
);
  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  // R11: control-port reads return all ones
  a_r11_ctrl_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == CTRL_ADDR) |-> (host_rdata == 8'hFF));

  // R3: at most one channel strobed per cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  // R4: a strobe follows a data-port write
  a_r4_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_load) |-> $past(host_wr && host_addr != CTRL_ADDR));

  // R3: the strobed channel is the one addressed a cycle earlier
  a_r3_strobe_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_load) |-> (ch_load == (ONE << $past(host_addr))));

  // R12: modes move only after a control-port write
  a_r12_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_wr && host_addr == CTRL_ADDR) |-> $stable(ch_mode));
endmodule

bind tmr_host_if tmr_host_if_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .ch_load    (ch_load),
  .ch_mode    (ch_mode)
);

// File: tb/tmr_host_if_bench.sv
`timescale 1ns/1ps
module tmr_host_if_bench;
  localparam int NCH = 3;

  logic            clk;
  logic            rst_n;
  logic [1:0]      host_addr;
  logic [7:0]      host_wdata;
  logic            host_wr;
  logic            host_rd;
  logic [7:0]      host_rdata;
  logic [NCH-1:0]  ch_load;
  logic [NCH*16-1:0] ch_value;
  logic [NCH*3-1:0]  ch_mode;
  logic [NCH*16-1:0] ch_count;
  logic [NCH-1:0]  ch_out;

  logic [15:0] m_cnt [NCH];
  int n_tests = 0;
  int n_fail  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  tmr_host_if #(.NUM_CH(NCH)) u_tmr_host_if (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .ch_load(ch_load), .ch_value(ch_value), .ch_mode(ch_mode),
    .ch_count(ch_count), .ch_out(ch_out)
  );

  // Simple channel model: the count takes each loaded value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) m_cnt[i] <= 16'h0000;
    end else begin
      for (int i = 0; i < NCH; i++) if (ch_load[i]) m_cnt[i] <= ch_value[i*16 +: 16];
    end
  end
  assign ch_count = {m_cnt[2], m_cnt[1], m_cnt[0]};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd_byte(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 no load after reset", ch_load, 3'b000);
    chk("R1 reset modes", ch_mode, 9'b011_011_011);
    rd_chk("R11 ctrl read after reset", 2'd3, 8'hFF);
    wr_byte(2'd3, 8'hE2);               // read-back status of channel 0
    rd_chk("R1 reset status ch0", 2'd0, 8'hB6);
    rd_chk("R1 live low byte after status", 2'd0, 8'h00);
  endtask

  task automatic t_single;
    wr_byte(2'd3, 8'h54);               // ch1, low only, mode 2
    chk("R12 ch1 mode 2", ch_mode[5:3], 3'd2);
    wr_byte(2'd1, 8'h5A);
    chk("R3 low-only strobe", ch_load, 3'b010);
    chk("R3 low-only value", ch_value[31:16], 16'h005A);
    wr_byte(2'd3, 8'h60);               // ch1, high only, mode 0
    wr_byte(2'd1, 8'hC3);
    chk("R3 high-only value", ch_value[31:16], 16'hC300);
    rd_chk("R7 high-only live read", 2'd1, 8'hC3);
    wr_byte(2'd3, 8'hE4);               // status ch1
    rd_chk("R2 status fields ch1", 2'd1, 8'h20);
  endtask

  task automatic t_word;
    wr_byte(2'd3, 8'hB9);               // ch2, word, mode 4, bcd
    chk("R12 ch2 mode 4", ch_mode[8:6], 3'd4);
    wr_byte(2'd2, 8'h34);
    chk("R4 no strobe on first byte", ch_load, 3'b000);
    wr_byte(2'd2, 8'h12);
    chk("R4 word strobe", ch_load, 3'b100);
    chk("R4 word value", ch_value[47:32], 16'h1234);
    wr_byte(2'd2, 8'h78);
    wr_byte(2'd2, 8'h56);
    chk("R4 toggle back to low", ch_value[47:32], 16'h5678);
    rd_chk("R7 live lo", 2'd2, 8'h78);
    rd_chk("R7 live hi", 2'd2, 8'h56);
    rd_chk("R7 live lo again", 2'd2, 8'h78);
  endtask

  task automatic t_latch;
    wr_byte(2'd3, 8'h34);               // ch0, word, mode 2
    wr_byte(2'd0, 8'hCD);
    wr_byte(2'd0, 8'hAB);
    wr_byte(2'd3, 8'h00);               // freeze ch0
    chk("R12 latch keeps mode", ch_mode[2:0], 3'd2);
    wr_byte(2'd0, 8'h11);
    wr_byte(2'd0, 8'h22);
    wr_byte(2'd3, 8'h00);               // ignored, one still waiting
    rd_chk("R5 frozen lo", 2'd0, 8'hCD);
    rd_chk("R6 frozen hi", 2'd0, 8'hAB);
    rd_chk("R6 released live lo", 2'd0, 8'h11);
    rd_chk("R6 released live hi", 2'd0, 8'h22);
    wr_byte(2'd3, 8'h00);
    rd_chk("R5 new freeze lo", 2'd0, 8'h11);
    rd_chk("R5 new freeze hi", 2'd0, 8'h22);
    wr_byte(2'd3, 8'h50);               // ch1, low only, mode 0
    wr_byte(2'd1, 8'h44);
    wr_byte(2'd3, 8'h40);
    wr_byte(2'd1, 8'h99);
    rd_chk("R6 single-byte frozen", 2'd1, 8'h44);
    rd_chk("R6 single-byte released", 2'd1, 8'h99);
  endtask

  task automatic t_readback;
    ch_out = 3'b101;
    wr_byte(2'd3, 8'hCA);               // count+status, ch0 and ch2
    rd_chk("R9 ch2 status first", 2'd2, 8'hB9);
    rd_chk("R8 ch2 frozen lo", 2'd2, 8'h78);
    rd_chk("R8 ch2 frozen hi", 2'd2, 8'h56);
    rd_chk("R9 ch0 status first", 2'd0, 8'hB4);
    rd_chk("R8 ch0 frozen lo", 2'd0, 8'h11);
    rd_chk("R8 ch0 frozen hi", 2'd0, 8'h22);
    rd_chk("R8 ch1 not picked", 2'd1, 8'h99);
    wr_byte(2'd3, 8'hE4);               // status ch1
    ch_out = 3'b111;
    wr_byte(2'd3, 8'hE4);               // ignored, status unread
    rd_chk("R9 old status kept", 2'd1, 8'h10);
    rd_chk("R9 live after status", 2'd1, 8'h99);
    wr_byte(2'd3, 8'hD2);               // count only, ch0
    wr_byte(2'd0, 8'h44);
    wr_byte(2'd0, 8'h33);
    rd_chk("R8 count-only lo", 2'd0, 8'h11);
    rd_chk("R8 count-only hi", 2'd0, 8'h22);
    rd_chk("R8 count-only then live", 2'd0, 8'h44);
  endtask

  task automatic t_toggle;
    wr_byte(2'd3, 8'hB9);
    rd_chk("R10 read toggle reset", 2'd2, 8'h78);
    wr_byte(2'd2, 8'hEF);
    wr_byte(2'd3, 8'hB9);               // clears both toggles
    wr_byte(2'd2, 8'h01);
    chk("R10 write toggle reset", ch_load, 3'b000);
    wr_byte(2'd2, 8'h02);
    chk("R10 word after reset", ch_value[47:32], 16'h0201);
    rd_chk("R10 live lo first", 2'd2, 8'h01);
  endtask

  task automatic t_ctrl_read;
    wr_byte(2'd3, 8'hE4);               // status ch1, out level 1
    rd_chk("R11 ctrl read 1", 2'd3, 8'hFF);
    rd_chk("R11 ctrl read 2", 2'd3, 8'hFF);
    chk("R11 no strobe", ch_load, 3'b000);
    rd_chk("R11 status untouched", 2'd1, 8'h90);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = 2'd0; host_wdata = 8'h00;
    host_wr = 1'b0; host_rd = 1'b0; ch_out = 3'b001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_single;
    t_word;
    t_latch;
    t_readback;
    t_toggle;
    t_ctrl_read;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule